// File: doc/BRIEF.md
# Mode and Error Flag Command Register

This block keeps the operating mode and the error record of a serial peripheral controller. Software never rewrites the state with a read-modify-write sequence. It writes a command word in which every state flag owns one set bit and one clear bit, and it reads a status word that shows the flags next to the live busy and received-byte-valid inputs of the shift engine. The engine and the FIFOs are not part of this block. They appear only as six error event inputs, one busy input and a 3-bit valid-byte count.

Two flags describe the mode. The enable flag picks configuration mode (0) or operational mode (1), and the master flag picks slave (0) or master (1). A four-state machine holds the pair: CFG_SLV, CFG_MST, RUN_SLV and RUN_MST. Its transitions are ENTER_RUN and ENTER_CFG on the enable strobes, and TAKE_MASTER and DROP_MASTER on the master strobes. Six sticky error flags record these conditions: mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. A control word gates which engine events may set those flags. An interrupt enable word masks the error interrupt.

Registers are word addressed. Offset 0 is the command word, offset 1 is status, offset 2 is control and offset 3 is interrupt enable. Writes take effect at the clock edge. Reads are combinational.

Top module: `ssc_cmd_state`

## Requirements
- R1: After reset all eight flags are 0, which means configuration mode as a slave. The mode outputs and err_irq are 0, and the status, control and interrupt enable words all read 0.
- R2: Offset 0 (command) reads as 0. Offset 2 (control) keeps only bits 12:8 and reads 0 elsewhere. Offset 3 (interrupt enable) keeps only bits 4:0.
- R3: Command bit 1 alone sets enable and bit 0 alone clears it. The op_mode output and status bit 0 show the enable flag.
- R4: Command bit 3 alone sets master select and bit 2 alone clears it. The master_sel output and status bit 1 show it.
- R5: Set strobes sit at command bit 7 (mode error), bits 12–15 (transmit overflow, receive overflow, abort, transmit underflow) and bit 5 (receive underflow). The matching clear strobes are bits 6, 8–11 and 4. Status shows the flags at bit 7 (mode error) and bits 8–12 (transmit overflow, receive overflow, abort, transmit underflow, receive underflow).
- R6: When one write carries both the set and the clear strobe of a flag, that flag keeps its value. This holds for the mode flags as well.
- R7: An error flag stays set until its clear strobe arrives or reset.
- R8: Event input hw_err_evt[i] uses index 0 for mode error, 1 for transmit overflow, 2 for receive overflow, 3 for abort, 4 for transmit underflow and 5 for receive underflow. Events 1 to 5 set their flag only when the control enable for that flag is 1. Those enables sit at control bits 8 to 12 for indices 1 to 5. A mode error event always sets its flag.
- R9: When an enabled event and a clear strobe hit the same flag in one cycle, the flag ends up set.
- R10: err_irq is 1 exactly when at least one error flag is set and interrupt enable bit 2 is 1.
- R11: Status bit 13 shows core_busy and status bits 30:28 show rx_bytes_valid. Every other unused status bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_err_evt | input | 6 | One-cycle error events from the shift engine |
| core_busy | input | 1 | Busy indication from the shift engine |
| rx_bytes_valid | input | 3 | Count of valid bytes in the last received word |
| op_mode | output | 1 | 1 = operational mode, 0 = configuration mode |
| master_sel | output | 1 | 1 = master, 0 = slave |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bound checker checks four behaviours on every cycle for each error flag. A set flag stays set unless its clear strobe is written. An enabled event always sets its flag. A clear flag stays clear when nothing sets it. A write that carries both enable strobes leaves the mode unchanged. It also checks that the interrupt is never raised with every flag clear. Some behaviours show up only in the bench scenarios: the exact bit positions of the strobes, enables and status fields, the precedence of an event over a clear, the interrupt mask bit, and the walk through all four mode states.

// File: rtl/ssc_cmd_pkg.sv
package ssc_cmd_pkg;

    localparam int BUS_W        = 32;
    localparam int NUM_ERR      = 6;
    localparam int CMD_W        = 16;
    localparam int CTRL_LO      = 8;
    localparam int CTRL_W       = 5;
    localparam int IE_W         = 5;
    localparam int IE_ERR_BIT   = 2;
    localparam int STAT_EN      = 0;
    localparam int STAT_MS      = 1;
    localparam int STAT_BUSY    = 13;
    localparam int STAT_RXBV_LO = 28;
    localparam int RXBV_W       = 3;

    // command bits for the mode flags
    localparam int CMD_EN_CLR = 0;
    localparam int CMD_EN_SET = 1;
    localparam int CMD_MS_CLR = 2;
    localparam int CMD_MS_SET = 3;

    // register word offsets
    localparam int REG_CMD  = 0;
    localparam int REG_STAT = 1;
    localparam int REG_CTRL = 2;
    localparam int REG_IE   = 3;

    // error flag indices
    localparam int ERR_MODE = 0;
    localparam int ERR_TXOV = 1;
    localparam int ERR_RXOV = 2;
    localparam int ERR_ABRT = 3;
    localparam int ERR_TXUN = 4;
    localparam int ERR_RXUN = 5;

    typedef enum logic [1:0] {
        CFG_SLV = 2'b00,
        CFG_MST = 2'b01,
        RUN_SLV = 2'b10,
        RUN_MST = 2'b11
    } mode_state_t;

    function automatic int err_clr_bit(input int idx);
        if (idx == ERR_MODE)      return 6;
        else if (idx == ERR_RXUN) return 4;
        else                      return 7 + idx;
    endfunction

    function automatic int err_set_bit(input int idx);
        if (idx == ERR_MODE)      return 7;
        else if (idx == ERR_RXUN) return 5;
        else                      return 11 + idx;
    endfunction

    function automatic int err_stat_bit(input int idx);
        return 7 + idx;
    endfunction

    // valid only for idx >= 1; mode error has no enable
    function automatic int err_ctrl_bit(input int idx);
        return 7 + idx;
    endfunction

endpackage

// File: rtl/ssc_mode_fsm.sv
module ssc_mode_fsm
    import ssc_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             op_mode,
    output logic             master_sel
);

    mode_state_t state_q, state_d;
    logic en_cur, ms_cur, en_nxt, ms_nxt;
    logic en_set, en_clr, ms_set, ms_clr;

    assign en_set = cmd_wr && cmd_word[CMD_EN_SET] && !cmd_word[CMD_EN_CLR];
    assign en_clr = cmd_wr && cmd_word[CMD_EN_CLR] && !cmd_word[CMD_EN_SET];
    assign ms_set = cmd_wr && cmd_word[CMD_MS_SET] && !cmd_word[CMD_MS_CLR];
    assign ms_clr = cmd_wr && cmd_word[CMD_MS_CLR] && !cmd_word[CMD_MS_SET];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_SLV;
        else        state_q <= state_d;
    end

    // next state: ENTER_RUN / ENTER_CFG / TAKE_MASTER / DROP_MASTER
    always_comb begin
        en_cur = 1'b0;
        ms_cur = 1'b0;
        unique case (state_q)
            CFG_SLV: begin en_cur = 1'b0; ms_cur = 1'b0; end
            CFG_MST: begin en_cur = 1'b0; ms_cur = 1'b1; end
            RUN_SLV: begin en_cur = 1'b1; ms_cur = 1'b0; end
            RUN_MST: begin en_cur = 1'b1; ms_cur = 1'b1; end
        endcase
        en_nxt = en_set ? 1'b1 : (en_clr ? 1'b0 : en_cur);
        ms_nxt = ms_set ? 1'b1 : (ms_clr ? 1'b0 : ms_cur);
        unique case ({en_nxt, ms_nxt})
            2'b00: state_d = CFG_SLV;
            2'b01: state_d = CFG_MST;
            2'b10: state_d = RUN_SLV;
            2'b11: state_d = RUN_MST;
        endcase
    end

    // outputs
    always_comb begin
        op_mode    = 1'b0;
        master_sel = 1'b0;
        unique case (state_q)
            CFG_SLV: begin op_mode = 1'b0; master_sel = 1'b0; end
            CFG_MST: begin op_mode = 1'b0; master_sel = 1'b1; end
            RUN_SLV: begin op_mode = 1'b1; master_sel = 1'b0; end
            RUN_MST: begin op_mode = 1'b1; master_sel = 1'b1; end
        endcase
    end

endmodule

// File: rtl/ssc_err_flag_bank.sv
module ssc_err_flag_bank
    import ssc_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic [NUM_ERR-1:0] hw_evt,
    input  logic [NUM_ERR-1:0] evt_en,
    output logic [NUM_ERR-1:0] flags
);

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
        localparam int SB = err_set_bit(i);
        localparam int CB = err_clr_bit(i);
        logic set_req, clr_req, hw_hit, flag_q, flag_d;

        assign set_req = cmd_wr && cmd_word[SB];
        assign clr_req = cmd_wr && cmd_word[CB];
        assign hw_hit  = hw_evt[i] && evt_en[i];

        // event beats clear; set+clear together holds the value
        always_comb begin
            if (hw_hit)                    flag_d = 1'b1;
            else if (set_req && !clr_req)  flag_d = 1'b1;
            else if (clr_req && !set_req)  flag_d = 1'b0;
            else                           flag_d = flag_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= flag_d;
        end

        assign flags[i] = flag_q;
    end

endmodule

// File: rtl/ssc_reg_port.sv
module ssc_reg_port
    import ssc_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wen,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_ERR-1:0] flags,
    input  logic               op_mode,
    input  logic               master_sel,
    input  logic               core_busy,
    input  logic [RXBV_W-1:0]  rx_bytes_valid,
    output logic               cmd_wr,
    output logic [CMD_W-1:0]   cmd_word,
    output logic [NUM_ERR-1:0] evt_en,
    output logic               err_irq
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(REG_IE);

    logic [CTRL_W-1:0] ctrl_q;
    logic [IE_W-1:0]   ie_q;
    logic [BUS_W-1:0]  stat_word;

    assign cmd_wr   = bus_wen && (bus_addr == A_CMD);
    assign cmd_word = bus_wdata[CMD_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ie_q   <= '0;
        end else if (bus_wen) begin
            if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_LO +: CTRL_W];
            if (bus_addr == A_IE)   ie_q   <= bus_wdata[IE_W-1:0];
        end
    end

    assign evt_en[ERR_MODE] = 1'b1;
    for (genvar i = 1; i < NUM_ERR; i++) begin : g_en
        assign evt_en[i] = ctrl_q[err_ctrl_bit(i) - CTRL_LO];
    end

    assign err_irq = ie_q[IE_ERR_BIT] && (|flags);

    always_comb begin
        stat_word = '0;
        stat_word[STAT_EN]   = op_mode;
        stat_word[STAT_MS]   = master_sel;
        for (int i = 0; i < NUM_ERR; i++) stat_word[err_stat_bit(i)] = flags[i];
        stat_word[STAT_BUSY] = core_busy;
        stat_word[STAT_RXBV_LO +: RXBV_W] = rx_bytes_valid;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT)      bus_rdata = stat_word;
        else if (bus_addr == A_CTRL) bus_rdata[CTRL_LO +: CTRL_W] = ctrl_q;
        else if (bus_addr == A_IE)   bus_rdata[IE_W-1:0] = ie_q;
    end

endmodule

// File: rtl/ssc_cmd_state.sv
module ssc_cmd_state
    import ssc_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wen,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_ERR-1:0] hw_err_evt,
    input  logic               core_busy,
    input  logic [RXBV_W-1:0]  rx_bytes_valid,
    output logic               op_mode,
    output logic               master_sel,
    output logic               err_irq
);

    logic               cmd_wr;
    logic [CMD_W-1:0]   cmd_word;
    logic [NUM_ERR-1:0] evt_en;
    logic [NUM_ERR-1:0] err_flags;

    ssc_reg_port #(.ADDR_W(ADDR_W)) u_port (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wen        (bus_wen),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .flags          (err_flags),
        .op_mode        (op_mode),
        .master_sel     (master_sel),
        .core_busy      (core_busy),
        .rx_bytes_valid (rx_bytes_valid),
        .cmd_wr         (cmd_wr),
        .cmd_word       (cmd_word),
        .evt_en         (evt_en),
        .err_irq        (err_irq)
    );

    ssc_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_word   (cmd_word),
        .op_mode    (op_mode),
        .master_sel (master_sel)
    );

    ssc_err_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_word),
        .hw_evt   (hw_err_evt),
        .evt_en   (evt_en),
        .flags    (err_flags)
    );

endmodule

// File: rtl/ssc_cmd_state_chk.sv
module ssc_cmd_state_chk
    import ssc_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wen,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic [NUM_ERR-1:0] hw_err_evt,
    input logic               op_mode,
    input logic               err_irq,
    input logic [NUM_ERR-1:0] flags,
    input logic [NUM_ERR-1:0] evt_en
);

    logic cmd_hit;
    assign cmd_hit = bus_wen && (bus_addr == ADDR_W'(REG_CMD));

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_chk
        localparam int SB = err_set_bit(i);
        localparam int CB = err_clr_bit(i);

        // R7
        sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(cmd_hit && bus_wdata[CB] && !bus_wdata[SB])) |=> flags[i]);

        // R8
        event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_err_evt[i] && evt_en[i]) |=> flags[i]);

        // R5
        quiet_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && !(hw_err_evt[i] && evt_en[i]) && !(cmd_hit && bus_wdata[SB]))
            |=> !flags[i]);
    end

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (flags != '0));

    // R6
    en_conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && bus_wdata[CMD_EN_SET] && bus_wdata[CMD_EN_CLR]) |=> $stable(op_mode));

    // R3
    en_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_hit |=> $stable(op_mode));

endmodule

bind ssc_cmd_state ssc_cmd_state_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wen    (bus_wen),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .hw_err_evt (hw_err_evt),
    .op_mode    (op_mode),
    .err_irq    (err_irq),
    .flags      (err_flags),
    .evt_en     (evt_en)
);

// File: tb/ssc_cmd_state_test.sv
module ssc_cmd_state_test;

    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  hw_err_evt = '0;
    logic        core_busy = 1'b0;
    logic [2:0]  rx_bytes_valid = '0;
    logic        op_mode, master_sel, err_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ssc_cmd_state #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_err_evt(hw_err_evt),
        .core_busy(core_busy), .rx_bytes_valid(rx_bytes_valid),
        .op_mode(op_mode), .master_sel(master_sel), .err_irq(err_irq)
    );

    // {command[15:0], events[5:0], expected status[12:0]}
    localparam logic [34:0] VEC [16] = '{
        {16'h0002, 6'h00, 13'h0001},  // R3 enter run
        {16'h0008, 6'h00, 13'h0003},  // R4 take master
        {16'h0001, 6'h00, 13'h0002},  // R3 back to config, master kept
        {16'h0003, 6'h00, 13'h0002},  // R6 both enable strobes
        {16'h0002, 6'h00, 13'h0003},  // R3
        {16'hF0A0, 6'h00, 13'h1F83},  // R5 set all errors
        {16'h0F50, 6'h00, 13'h0003},  // R5 clear all errors
        {16'h0000, 6'h03, 13'h0183},  // R8 mode + tx overflow events
        {16'h0040, 6'h01, 13'h0183},  // R9 event beats clear
        {16'h1100, 6'h00, 13'h0183},  // R6 set+clear tx overflow
        {16'h0140, 6'h00, 13'h0003},  // R5
        {16'h0000, 6'h3C, 13'h1E03},  // R8 rx ov, abort, tx un, rx un
        {16'h0214, 6'h00, 13'h0C01},  // R4 R5 drop master, clear two
        {16'h0000, 6'h00, 13'h0C01},  // R7 sticky
        {16'h0C00, 6'h00, 13'h0001},  // R5
        {16'h0001, 6'h00, 13'h0000}   // R3 config slave
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic wen, input int a, input logic [31:0] d, input logic [5:0] e);
        @(negedge clk);
        bus_wen = wen;
        bus_addr = AW'(a);
        bus_wdata = d;
        hw_err_evt = e;
        @(negedge clk);
        bus_wen = 1'b0;
        hw_err_evt = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = AW'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1, v); check("R1 status", v, 32'h0);
        check("R1 op_mode", {31'b0, op_mode}, 32'h0);
        check("R1 master_sel", {31'b0, master_sel}, 32'h0);
        check("R1 err_irq", {31'b0, err_irq}, 32'h0);
        rd(2, v); check("R1 control", v, 32'h0);
        rd(3, v); check("R1 irq enable", v, 32'h0);

        // R2 register map
        step(1'b1, 2, 32'hFFFF_FFFF, 6'h00);
        rd(2, v); check("R2 control bits", v, 32'h0000_1F00);
        step(1'b1, 3, 32'hFFFF_FFFF, 6'h00);
        rd(3, v); check("R2 irq enable bits", v, 32'h0000_001F);
        rd(0, v); check("R2 command reads zero", v, 32'h0);
        step(1'b1, 3, 32'h0000_0004, 6'h00);

        // table walk
        for (int k = 0; k < 16; k++) begin
            step(1'b1, 0, {16'h0, VEC[k][34:19]}, VEC[k][18:13]);
            rd(1, v);
            check($sformatf("R3-R9 vector %0d status", k), v, {19'b0, VEC[k][12:0]});
            check($sformatf("R3 vector %0d op_mode", k), {31'b0, op_mode}, {31'b0, VEC[k][0]});
            check($sformatf("R4 vector %0d master_sel", k), {31'b0, master_sel}, {31'b0, VEC[k][1]});
            check($sformatf("R10 vector %0d err_irq", k), {31'b0, err_irq},
                  {31'b0, (VEC[k][12:7] != 6'h0)});
        end

        // R8 disabled enables block events 1..5, mode error still sets
        step(1'b1, 2, 32'h0, 6'h00);
        step(1'b0, 1, 32'h0, 6'h3E);
        rd(1, v); check("R8 disabled events ignored", v, 32'h0);
        check("R10 no irq without flag", {31'b0, err_irq}, 32'h0);
        step(1'b0, 1, 32'h0, 6'h01);
        rd(1, v); check("R8 mode event unconditional", v, 32'h0000_0080);
        check("R10 irq with flag and mask", {31'b0, err_irq}, 32'h1);

        // R10 mask bit 2 only
        step(1'b1, 3, 32'h0000_001B, 6'h00);
        check("R10 masked irq", {31'b0, err_irq}, 32'h0);
        step(1'b1, 3, 32'h0000_0004, 6'h00);
        check("R10 unmasked irq", {31'b0, err_irq}, 32'h1);
        step(1'b1, 0, 32'h0000_0040, 6'h00);
        check("R10 clear drops irq", {31'b0, err_irq}, 32'h0);

        // R11 pass-through fields
        core_busy = 1'b1;
        rx_bytes_valid = 3'd5;
        rd(1, v); check("R11 busy and valid bytes", v, 32'h5000_2000);
        core_busy = 1'b0;
        rx_bytes_valid = 3'd0;
        rd(1, v); check("R11 fields cleared", v, 32'h0);

        finish_run();
    end

endmodule